// File: doc/BRIEF.md
# Victim-Aggressor Pattern Expander

This engine fills a test-pattern write buffer with crosstalk stress data. Each of its 32 lanes is either a victim, an aggressor, both or neither. That role picks a fixed 8-bit burst code for the lane. The codes are then transposed into eight chunk words per buffer line. Each 32-bit chunk word is repeated into both halves of a 64-bit write.

A job covers several consecutive lines. After each line, the victim and aggressor masks rotate left by one lane, so the stressed lanes walk across the bus.

A job comes in one of two forms:
- **Single job:** the caller supplies the two masks, a rotation count and a first line.
- **Default fill:** the engine runs a built-in program of ten jobs that covers 62 contiguous lines from the given first line.

Writes leave on a valid/ready stream that carries line, chunk and data. The sink may hold `wr_ready` low on any cycle. While it does, the engine keeps the offered write unchanged and sends nothing further. One write is accepted on each cycle in which `wr_valid` and `wr_ready` are both high. `wr_valid` never depends on `wr_ready` in the same cycle. Control uses plain level pins `start`, `busy` and `done`.

Top module: `va_pattern_expander`

## Requirements
- R1: The lane code index is {not victim bit, aggressor bit}. Index values 0, 1, 2 and 3 select burst codes 0xAA, 0xC0, 0xCC and 0xF0.
- R2: For chunk c (0..7), bit b of the 32-bit chunk word equals bit c of lane b's burst code.
- R3: Every 64-bit write carries the 32-bit chunk word in bits 31:0 and again in bits 63:32.
- R4: Rotation v of a single job writes chunks 0,1,...,7 in that order to line start_line+v, modulo 2^LINE_W.
- R5: Between rotations, both masks rotate left by one, and bit 31 wraps into bit 0.
- R6: `wr_valid` stays high through a job, so one write is accepted per cycle while `wr_ready` is high. While `wr_valid` is high and `wr_ready` is low, `wr_line`, `wr_chunk` and `wr_data` hold steady.
- R7: `done` is high for exactly one cycle: the cycle after the last write is accepted. `busy` is high from the cycle after `start` is accepted through the `done` cycle.
- R8: A single job with rotation count 0 raises `done` in the cycle after `start` and issues no writes.
- R9: `start` is ignored while `busy` is high. The job in progress and its write stream are unaffected.
- R10: With `fill_default` high at start, the engine runs two phases.
  - Phase one: 8 rotations with aggressor 0 and victim 0x01010101, starting at start_line.
  - Phase two: aggressor masks 0x86186186, 0x18618618, 0x30c30c30, 0xa28a28a2, 0x8a28a28a, 0x14514514, 0x28a28a28, 0x92492492 and 0x24924924, in that order. Each uses victim 0x41041041 and 6 rotations, beginning at start_line+8 and advancing 6 lines per mask.
  - The mask and count inputs are ignored.
- R11: After reset, `busy`, `done` and `wr_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a job when idle |
| fill_default | input | 1 | Select the built-in two-phase fill program |
| agg_mask | input | 32 | Aggressor lanes for a single job |
| vic_mask | input | 32 | Victim lanes for a single job |
| rot_count | input | ROT_W | Number of rotations (lines) for a single job |
| start_line | input | LINE_W | First buffer line |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle completion pulse |
| wr_valid | output | 1 | Buffer write offered |
| wr_ready | input | 1 | Sink accepts the offered write |
| wr_line | output | LINE_W | Buffer line of the write |
| wr_chunk | output | 3 | Chunk index within the line |
| wr_data | output | 64 | Chunk data |

## Verification
Two events can fall in the same cycle:
- **Start during a write.** A `start` pulse can arrive while a write is being offered. The bench changes the masks and pulses `start` mid-job. It then judges that the recorded write stream still matches the first job, entry for entry.
- **Stall on the final chunk.** The last chunk of a job can meet a stall. Random back-pressure holds `wr_ready` low on arbitrary cycles, including the final chunk. The bench requires `done` to appear only in the cycle after that chunk is actually accepted, never while the chunk is still held.

// File: rtl/vap_pkg.sv
package vap_pkg;
  localparam int MASK_W   = 32;
  localparam int CHUNKS   = 8;
  localparam int CHUNK_W  = $clog2(CHUNKS);
  localparam int NUM_JOBS = 10;
  localparam int JOB_W    = $clog2(NUM_JOBS + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} vap_state_e;

  // Lane burst code selected by {~victim, aggressor}
  function automatic logic [CHUNKS-1:0] burst_code(input logic [1:0] idx);
    case (idx)
      2'd0:    burst_code = 8'hAA;
      2'd1:    burst_code = 8'hC0;
      2'd2:    burst_code = 8'hCC;
      default: burst_code = 8'hF0;
    endcase
  endfunction

  function automatic logic [MASK_W-1:0] rol1(input logic [MASK_W-1:0] m);
    rol1 = {m[MASK_W-2:0], m[MASK_W-1]};
  endfunction
endpackage

// File: rtl/vap_word_builder.sv
module vap_word_builder
  import vap_pkg::*;
(
  input  logic [MASK_W-1:0]  agg,
  input  logic [MASK_W-1:0]  vic,
  input  logic [CHUNK_W-1:0] chunk,
  output logic [MASK_W-1:0]  word
);
  for (genvar b = 0; b < MASK_W; b++) begin : g_lane
    logic [CHUNKS-1:0] code;
    assign code    = burst_code({~vic[b], agg[b]});
    assign word[b] = code[chunk];
  end
endmodule

// File: rtl/vap_job_rom.sv
module vap_job_rom
  import vap_pkg::*;
#(
  parameter int ROT_W  = 8,
  parameter int LINE_W = 12
) (
  input  logic [JOB_W-1:0]  job,
  output logic [MASK_W-1:0] agg,
  output logic [MASK_W-1:0] vic,
  output logic [ROT_W-1:0]  rot,
  output logic [LINE_W-1:0] offset
);
  localparam int FIRST_ROTS = 8;
  localparam int LATER_ROTS = 6;

  function automatic logic [MASK_W-1:0] phase2_agg(input logic [JOB_W-1:0] k);
    case (k)
      4'd0:    phase2_agg = 32'h86186186;
      4'd1:    phase2_agg = 32'h18618618;
      4'd2:    phase2_agg = 32'h30c30c30;
      4'd3:    phase2_agg = 32'ha28a28a2;
      4'd4:    phase2_agg = 32'h8a28a28a;
      4'd5:    phase2_agg = 32'h14514514;
      4'd6:    phase2_agg = 32'h28a28a28;
      4'd7:    phase2_agg = 32'h92492492;
      default: phase2_agg = 32'h24924924;
    endcase
  endfunction

  always_comb begin
    if (job == '0) begin
      agg    = '0;
      vic    = 32'h01010101;
      rot    = ROT_W'(FIRST_ROTS);
      offset = '0;
    end else begin
      agg    = phase2_agg(job - JOB_W'(1));
      vic    = 32'h41041041;
      rot    = ROT_W'(LATER_ROTS);
      offset = LINE_W'(FIRST_ROTS + LATER_ROTS * (int'(job) - 1));
    end
  end
endmodule

// File: rtl/vap_ctrl.sv
module vap_ctrl
  import vap_pkg::*;
#(
  parameter int ROT_W  = 8,
  parameter int LINE_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               fill_default,
  input  logic [MASK_W-1:0]  agg_mask,
  input  logic [MASK_W-1:0]  vic_mask,
  input  logic [ROT_W-1:0]   rot_count,
  input  logic [LINE_W-1:0]  start_line,
  input  logic               wr_ready,
  output logic [JOB_W-1:0]   rom_job,
  input  logic [MASK_W-1:0]  rom_agg,
  input  logic [MASK_W-1:0]  rom_vic,
  input  logic [ROT_W-1:0]   rom_rot,
  input  logic [LINE_W-1:0]  rom_off,
  output logic               busy,
  output logic               done,
  output logic               wr_valid,
  output logic [LINE_W-1:0]  cur_line,
  output logic [CHUNK_W-1:0] cur_chunk,
  output logic [MASK_W-1:0]  cur_agg,
  output logic [MASK_W-1:0]  cur_vic
);
  localparam logic [CHUNK_W-1:0] CHUNK_LAST = CHUNK_W'(CHUNKS - 1);
  localparam logic [JOB_W-1:0]   JOB_LAST   = JOB_W'(NUM_JOBS - 1);

  vap_state_e         state_q;
  logic               fill_q;
  logic [JOB_W-1:0]   job_q;
  logic [ROT_W-1:0]   rot_q, rot_idx_q;
  logic [LINE_W-1:0]  line_q, base_q;
  logic [CHUNK_W-1:0] chunk_q;
  logic [MASK_W-1:0]  agg_q, vic_q;

  assign rom_job = (state_q == ST_IDLE) ? '0 : job_q + JOB_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      fill_q    <= 1'b0;
      job_q     <= '0;
      rot_q     <= '0;
      rot_idx_q <= '0;
      line_q    <= '0;
      base_q    <= '0;
      chunk_q   <= '0;
      agg_q     <= '0;
      vic_q     <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start) begin
          fill_q    <= fill_default;
          job_q     <= '0;
          chunk_q   <= '0;
          rot_idx_q <= '0;
          base_q    <= start_line;
          if (fill_default) begin
            agg_q   <= rom_agg;
            vic_q   <= rom_vic;
            rot_q   <= rom_rot;
            line_q  <= start_line + rom_off;
            state_q <= ST_RUN;
          end else begin
            agg_q   <= agg_mask;
            vic_q   <= vic_mask;
            rot_q   <= rot_count;
            line_q  <= start_line;
            state_q <= (rot_count == '0) ? ST_DONE : ST_RUN;
          end
        end
        ST_RUN: if (wr_ready) begin
          if (chunk_q != CHUNK_LAST) begin
            chunk_q <= chunk_q + CHUNK_W'(1);
          end else begin
            chunk_q <= '0;
            line_q  <= line_q + LINE_W'(1);
            if (rot_idx_q == rot_q - ROT_W'(1)) begin
              if (fill_q && job_q != JOB_LAST) begin
                job_q     <= job_q + JOB_W'(1);
                agg_q     <= rom_agg;
                vic_q     <= rom_vic;
                rot_q     <= rom_rot;
                rot_idx_q <= '0;
                line_q    <= base_q + rom_off;
              end else begin
                state_q <= ST_DONE;
              end
            end else begin
              rot_idx_q <= rot_idx_q + ROT_W'(1);
              agg_q     <= rol1(agg_q);
              vic_q     <= rol1(vic_q);
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign done      = (state_q == ST_DONE);
  assign wr_valid  = (state_q == ST_RUN);
  assign cur_line  = line_q;
  assign cur_chunk = chunk_q;
  assign cur_agg   = agg_q;
  assign cur_vic   = vic_q;
endmodule

// File: rtl/va_pattern_expander.sv
module va_pattern_expander
  import vap_pkg::*;
#(
  parameter int ROT_W  = 8,
  parameter int LINE_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                fill_default,
  input  logic [MASK_W-1:0]   agg_mask,
  input  logic [MASK_W-1:0]   vic_mask,
  input  logic [ROT_W-1:0]    rot_count,
  input  logic [LINE_W-1:0]   start_line,
  output logic                busy,
  output logic                done,
  output logic                wr_valid,
  input  logic                wr_ready,
  output logic [LINE_W-1:0]   wr_line,
  output logic [CHUNK_W-1:0]  wr_chunk,
  output logic [2*MASK_W-1:0] wr_data
);
  logic [JOB_W-1:0]  rom_job;
  logic [MASK_W-1:0] rom_agg, rom_vic, cur_agg, cur_vic, word;
  logic [ROT_W-1:0]  rom_rot;
  logic [LINE_W-1:0] rom_off;

  vap_job_rom #(.ROT_W(ROT_W), .LINE_W(LINE_W)) u_rom (
    .job(rom_job), .agg(rom_agg), .vic(rom_vic), .rot(rom_rot), .offset(rom_off)
  );

  vap_ctrl #(.ROT_W(ROT_W), .LINE_W(LINE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .fill_default(fill_default),
    .agg_mask(agg_mask), .vic_mask(vic_mask), .rot_count(rot_count),
    .start_line(start_line), .wr_ready(wr_ready), .rom_job(rom_job),
    .rom_agg(rom_agg), .rom_vic(rom_vic), .rom_rot(rom_rot), .rom_off(rom_off),
    .busy(busy), .done(done), .wr_valid(wr_valid), .cur_line(wr_line),
    .cur_chunk(wr_chunk), .cur_agg(cur_agg), .cur_vic(cur_vic)
  );

  vap_word_builder u_word (
    .agg(cur_agg), .vic(cur_vic), .chunk(wr_chunk), .word(word)
  );

  assign wr_data = {word, word};
endmodule

// File: rtl/vap_checker.sv
module vap_checker
  import vap_pkg::*;
#(
  parameter int LINE_W = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic                busy,
  input logic                done,
  input logic                wr_valid,
  input logic                wr_ready,
  input logic [LINE_W-1:0]   wr_line,
  input logic [CHUNK_W-1:0]  wr_chunk,
  input logic [2*MASK_W-1:0] wr_data
);
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_line) && $stable(wr_chunk) && $stable(wr_data));

  p_chunk_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready && wr_chunk != CHUNK_W'(CHUNKS - 1)
    |=> wr_valid && wr_chunk == $past(wr_chunk) + CHUNK_W'(1) && wr_line == $past(wr_line));

  p_line_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready && wr_chunk == CHUNK_W'(CHUNKS - 1)
    |=> !wr_valid || (wr_chunk == '0 && wr_line == $past(wr_line) + LINE_W'(1)));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  p_done_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy && !wr_valid);

  p_valid_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> busy);

  p_mirror_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_data[2*MASK_W-1:MASK_W] == wr_data[MASK_W-1:0]);
endmodule

bind va_pattern_expander vap_checker #(.LINE_W(LINE_W)) u_vap_checker (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .wr_valid(wr_valid),
  .wr_ready(wr_ready), .wr_line(wr_line), .wr_chunk(wr_chunk), .wr_data(wr_data)
);

// File: tb/tb_va_pattern_expander.sv
module tb_va_pattern_expander;
  localparam int CLK_PERIOD = 10;
  localparam int ROT_W = 8;
  localparam int LINE_W = 12;
  localparam int MAXE = 1024;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, fill_default = 1'b0, wr_ready = 1'b0;
  logic [31:0] agg_mask = '0, vic_mask = '0;
  logic [ROT_W-1:0] rot_count = '0;
  logic [LINE_W-1:0] start_line = '0;
  logic busy, done, wr_valid;
  logic [LINE_W-1:0] wr_line;
  logic [2:0] wr_chunk;
  logic [63:0] wr_data;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [63:0] e_data [MAXE];
  int e_line [MAXE];
  int e_chunk [MAXE];
  int n_exp;

  always #(CLK_PERIOD/2) clk = ~clk;

  va_pattern_expander #(.ROT_W(ROT_W), .LINE_W(LINE_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .fill_default(fill_default),
    .agg_mask(agg_mask), .vic_mask(vic_mask), .rot_count(rot_count),
    .start_line(start_line), .busy(busy), .done(done), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_line(wr_line), .wr_chunk(wr_chunk), .wr_data(wr_data)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(1'b0, "watchdog", 64'(cyc), 64'd150000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  // R1: {~v,a} = 0:AA 1:C0 2:CC 3:F0
  function automatic logic [7:0] bf_code(input logic v, input logic a);
    if (v && !a) return 8'hAA;
    if (v && a)  return 8'hC0;
    if (!v && !a) return 8'hCC;
    return 8'hF0;
  endfunction

  // R2/R3: transpose, then mirror
  function automatic logic [63:0] bf_data(input logic [31:0] a, input logic [31:0] v, input int c);
    logic [31:0] w;
    logic [7:0] code;
    for (int b = 0; b < 32; b++) begin
      code = bf_code(v[b], a[b]);
      w[b] = code[c];
    end
    return {w, w};
  endfunction

  // R5: rotate left by one
  function automatic logic [31:0] bf_rol(input logic [31:0] m);
    return {m[30:0], m[31]};
  endfunction

  task automatic add_job(input logic [31:0] a, input logic [31:0] v, input int rot, input int line);
    logic [31:0] ca = a, cv = v;
    for (int r = 0; r < rot; r++) begin
      for (int c = 0; c < 8; c++) begin
        e_data[n_exp] = bf_data(ca, cv, c);
        e_line[n_exp] = (line + r) % (1 << LINE_W);
        e_chunk[n_exp] = c;
        n_exp++;
      end
      ca = bf_rol(ca);
      cv = bf_rol(cv);
    end
  endtask

  task automatic build_fill(input int base);  // R10
    logic [31:0] am [9] = '{32'h86186186, 32'h18618618, 32'h30c30c30,
                            32'ha28a28a2, 32'h8a28a28a, 32'h14514514,
                            32'h28a28a28, 32'h92492492, 32'h24924924};
    n_exp = 0;
    add_job(32'h0, 32'h01010101, 8, base);
    for (int k = 0; k < 9; k++) add_job(am[k], 32'h41041041, 6, base + 8 + 6 * k);
  endtask

  // Run one job, compare every accepted write, then check the done pulse (R6, R7, R9)
  task automatic run_job(input string tag, input bit fill, input bit bp, input bit poke,
                         input logic [31:0] a, input logic [31:0] v, input int rot, input int line);
    int idx = 0, t = 0;
    bit fin = 0, prev_last, poked = 0;
    prev_last = (n_exp == 0);
    @(negedge clk);
    fill_default = fill; agg_mask = a; vic_mask = v;
    rot_count = ROT_W'(rot); start_line = LINE_W'(line); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!fin && t < 5000) begin
      wr_ready = bp ? 1'($urandom % 2) : 1'b1;
      if (poke && idx == 3 && !poked) begin
        start = 1'b1; agg_mask = ~a; vic_mask = ~v; rot_count = 8'd1; fill_default = ~fill;
        poked = 1;
      end else start = 1'b0;
      #1;
      if (done) begin
        chk(idx == n_exp && prev_last && !wr_valid, {tag, " R7 done timing"}, 64'(idx), 64'(n_exp));
        fin = 1;
      end else if (wr_valid && wr_ready) begin
        if (idx >= n_exp) begin
          chk(1'b0, {tag, " R8 extra write"}, 64'(idx), 64'(n_exp));
          fin = 1;
        end else begin
          chk(wr_data == e_data[idx], {tag, " R2 data"}, wr_data, e_data[idx]);
          chk(int'(wr_line) == e_line[idx] && int'(wr_chunk) == e_chunk[idx],
              {tag, " R4 line/chunk"}, {wr_line, 1'b0, wr_chunk}, 64'(e_line[idx] * 16 + e_chunk[idx]));
          idx++;
          prev_last = (idx == n_exp);
        end
      end else begin
        if (!(poke && poked)) chk(busy, {tag, " R7 busy"}, 64'(busy), 64'd1);
        prev_last = 0;
      end
      @(negedge clk);
      t++;
    end
    start = 1'b0;
    if (!fin) chk(1'b0, {tag, " R7 no done"}, 64'(idx), 64'(n_exp));
    #1;
    chk(!done && !busy, {tag, " R7 pulse width"}, 64'(done), 64'd0);
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    #1;
    chk(!busy && !done && !wr_valid, "R11 reset", {busy, done, wr_valid}, 64'd0);
    rst_n = 1'b1;

    // R1: all victims, no aggressors -> code 0xAA everywhere
    n_exp = 0; add_job(32'h0, 32'hFFFFFFFF, 1, 5);
    run_job("R1 vic-only", 0, 0, 0, 32'h0, 32'hFFFFFFFF, 1, 5);
    // R1 index 3 -> code 0xF0
    n_exp = 0; add_job(32'hFFFFFFFF, 32'h0, 1, 6);
    run_job("R1 agg-only", 0, 0, 0, 32'hFFFFFFFF, 32'h0, 1, 6);
    // R5 wrap of bit 31, R4 line wrap
    n_exp = 0; add_job(32'h80000001, 32'h80000000, 3, 4094);
    run_job("R5 wrap", 0, 1, 0, 32'h80000001, 32'h80000000, 3, 4094);
    // R8 zero rotations
    n_exp = 0;
    run_job("R8 zero", 0, 0, 0, 32'h1234, 32'h5678, 0, 9);
    // R9 start while busy
    n_exp = 0; add_job(32'hA5A5A5A5, 32'h0F0F0F0F, 4, 100);
    run_job("R9 poke", 0, 1, 1, 32'hA5A5A5A5, 32'h0F0F0F0F, 4, 100);
    // Random single jobs with back-pressure (R6)
    for (int j = 0; j < 8; j++) begin
      logic [31:0] a, v;
      int r, l;
      a = $urandom; v = $urandom; r = 1 + ($urandom % 12); l = $urandom % 4096;
      n_exp = 0; add_job(a, v, r, l);
      run_job("R6 random", 0, j % 2 == 1, 0, a, v, r, l);
    end
    // R10 default fill, masks and count ignored
    build_fill(200);
    run_job("R10 fill", 1, 0, 0, 32'hDEADBEEF, 32'h0, 0, 200);
    build_fill(4090);
    run_job("R10 fill bp", 1, 1, 0, 32'h1, 32'h2, 3, 4090);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule